// File: doc/BRIEF.md
# Complementary Dead-Time Drive Generator

This block turns a single PWM command into two gate-drive enables for a complementary switch pair: a main power switch and an auxiliary switch. Each edge of the command has its own dead-time. On a rising edge the auxiliary switch is released at once, and the power switch follows after the turn-on delay. On a falling edge the power switch is released at once, and the auxiliary switch follows after the turn-off delay. Both delays are clock-cycle counts taken from configuration inputs. A zero-voltage sense input per timer can end its delay early, so a soft-switching converter can close the switch as soon as the voltage across it has collapsed.

An enable input puts the block to sleep. In sleep the power drive is held low and the auxiliary drive is released to high impedance through an output-enable. A polarity input chooses how the auxiliary drive is encoded: as the true complement of the power drive, or inverted for a P-channel switch. The PWM command crosses into the clock domain through a two-flop synchronizer, and all delays are counted from the synchronized edge.

Top module: `comp_deadtime_drv`

## Requirements
- R1: After reset with `drv_en` high and `aux_inv` low, `pwr_gate` is 0, `aux_oe` is 1 and `aux_gate` is 1 (auxiliary switch on).
- R2: A change on `pwm_in` made between clock edges first shows on the outputs after the third rising clock edge that follows it (two synchronizer flops, then the state register).
- R3: On a synchronized rising PWM edge the auxiliary switch turns off on that same state edge. With `dly_on_cyc` = D ≥ 1, the power switch turns on exactly D clock edges later.
- R4: On a synchronized falling PWM edge the power switch turns off on that same state edge. With `dly_off_cyc` = D ≥ 1, the auxiliary switch turns on exactly D clock edges later.
- R5: A delay setting of 0 gives no dead-time: both switches change on the same clock edge.
- R6: If `zvs_on` is high at a clock edge while the turn-on delay is counting, the power switch turns on at that edge. The same holds for `zvs_off` and the turn-off delay. A sense input is ignored while its timer is idle.
- R7: A falling PWM edge during the turn-on delay cancels the pending power turn-on and starts the turn-off delay. A rising edge during the turn-off delay cancels the pending auxiliary turn-on, keeps the auxiliary switch off and starts a fresh turn-on delay.
- R8: A delay input changed while its timer counts takes effect only from the next PWM edge.
- R9: While `drv_en` is 0, `pwr_gate`, `aux_gate` and `aux_oe` are all 0, with no clock latency.
- R10: On leaving sleep the block is in the input-low state (power off, auxiliary on). A PWM level that is already high at wake-up starts no cycle; the next rising edge starts a normal turn-on delay.
- R11: With `aux_inv` = 0, `aux_gate` = 1 means the auxiliary switch is on. With `aux_inv` = 1, `aux_gate` = 0 means the auxiliary switch is on.
- R12: While `drv_en` is 1, the power switch and the auxiliary switch are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | Asynchronous PWM command |
| drv_en | input | 1 | 1 = run, 0 = sleep |
| aux_inv | input | 1 | Auxiliary drive polarity select |
| dly_on_cyc | input | DLY_W | Dead-time from auxiliary off to power on, in cycles |
| dly_off_cyc | input | DLY_W | Dead-time from power off to auxiliary on, in cycles |
| zvs_on | input | 1 | Zero-voltage sense that ends the turn-on delay |
| zvs_off | input | 1 | Zero-voltage sense that ends the turn-off delay |
| pwr_gate | output | 1 | Power switch drive, 1 = on |
| aux_gate | output | 1 | Auxiliary switch drive, encoding set by `aux_inv` |
| aux_oe | output | 1 | Auxiliary drive output-enable, 0 = high impedance |

## Verification
Two functions can land on the same clock edge here. A PWM edge can arrive while the opposite timer is still counting, so the cancel path and the start of the new timer resolve together. A zero-voltage sense pulse can also coincide with the natural end of a count. The bench creates the first case by toggling the PWM input a few cycles into each delay. It then checks that the cancelled switch never turns on and that the other switch switches on the exact edge the requirements give. The sense inputs are pulsed mid-count and also while their timer is idle. A continuous monitor confirms that the two switches never overlap.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    localparam int unsigned SYNC_STAGES = 2;
    localparam int unsigned N_TIMERS    = 2;
    localparam int unsigned T_ON        = 0;
    localparam int unsigned T_OFF       = 1;

    // Commanded switch states, 1 = switch on
    typedef struct packed {
        logic pwr;
        logic aux;
    } sw_cmd_t;

    localparam sw_cmd_t IDLE_CMD = '{pwr: 1'b0, aux: 1'b1};

    typedef struct packed {
        logic rise;
        logic fall;
        logic on_fire;
        logic off_fire;
    } drv_evt_t;

    function automatic sw_cmd_t next_cmd(input sw_cmd_t cur, input drv_evt_t ev);
        sw_cmd_t n;
        n = cur;
        if (ev.rise) begin
            n.aux = 1'b0;
            n.pwr = ev.on_fire;
        end else if (ev.fall) begin
            n.pwr = 1'b0;
            n.aux = ev.off_fire;
        end else begin
            if (ev.on_fire)  n.pwr = 1'b1;
            if (ev.off_fire) n.aux = 1'b1;
        end
        return n;
    endfunction

endpackage

// File: rtl/cdt_edge_sync.sv
module cdt_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q[0] <= async_in;
            prev_q     <= chain_q[STAGES-1];
        end
    end

    for (genvar gi = 1; gi < STAGES; gi++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain_q[gi] <= 1'b0;
            else     chain_q[gi] <= chain_q[gi-1];
        end
    end

    assign level = chain_q[STAGES-1];
    assign rise  = level & ~prev_q;
    assign fall  = ~level & prev_q;
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         abort,
    input  logic [W-1:0] dly,
    input  logic         zvs,
    output logic         fire,
    output logic         running
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;
    logic         run_q;

    always_comb begin
        fire = 1'b0;
        if (start)
            fire = (dly == '0);
        else if (run_q && !abort)
            fire = (cnt_q == ONE) || zvs;
    end

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            run_q <= (dly != '0);
            cnt_q <= dly;
        end else if (fire) begin
            run_q <= 1'b0;
        end else if (run_q) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign running = run_q;
endmodule

// File: rtl/cdt_out_stage.sv
module cdt_out_stage
    import cdt_pkg::*;
(
    input  sw_cmd_t cmd,
    input  logic    drv_en,
    input  logic    aux_inv,
    output logic    pwr_gate,
    output logic    aux_gate,
    output logic    aux_oe
);
    assign pwr_gate = drv_en & cmd.pwr;
    assign aux_gate = drv_en & (cmd.aux ^ aux_inv);
    assign aux_oe   = drv_en;
endmodule

// File: rtl/comp_deadtime_drv.sv
module comp_deadtime_drv
    import cdt_pkg::*;
#(
    parameter int unsigned DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwm_in,
    input  logic             drv_en,
    input  logic             aux_inv,
    input  logic [DLY_W-1:0] dly_on_cyc,
    input  logic [DLY_W-1:0] dly_off_cyc,
    input  logic             zvs_on,
    input  logic             zvs_off,
    output logic             pwr_gate,
    output logic             aux_gate,
    output logic             aux_oe
);
    logic    pwm_lvl, rise_p, fall_p;
    sw_cmd_t cmd_q, cmd_d;
    drv_evt_t evt;

    logic [N_TIMERS-1:0]            t_start, t_abort, t_zvs, t_fire, t_run;
    logic [N_TIMERS-1:0][DLY_W-1:0] t_dly;

    logic pwr_on_q, aux_on_q;

    cdt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pwm_in),
        .level    (pwm_lvl),
        .rise     (rise_p),
        .fall     (fall_p)
    );

    assign t_start[T_ON]  = drv_en & rise_p;
    assign t_abort[T_ON]  = fall_p | ~drv_en;
    assign t_dly[T_ON]    = dly_on_cyc;
    assign t_zvs[T_ON]    = zvs_on;
    assign t_start[T_OFF] = drv_en & fall_p;
    assign t_abort[T_OFF] = rise_p | ~drv_en;
    assign t_dly[T_OFF]   = dly_off_cyc;
    assign t_zvs[T_OFF]   = zvs_off;

    for (genvar gi = 0; gi < N_TIMERS; gi++) begin : g_timer
        cdt_timer #(.W(DLY_W)) u_tmr (
            .clk     (clk),
            .rst     (rst),
            .start   (t_start[gi]),
            .abort   (t_abort[gi]),
            .dly     (t_dly[gi]),
            .zvs     (t_zvs[gi]),
            .fire    (t_fire[gi]),
            .running (t_run[gi])
        );
    end

    always_comb begin
        evt.rise     = rise_p;
        evt.fall     = fall_p;
        evt.on_fire  = t_fire[T_ON];
        evt.off_fire = t_fire[T_OFF];
        cmd_d        = drv_en ? next_cmd(cmd_q, evt) : IDLE_CMD;
    end

    always_ff @(posedge clk) begin
        if (rst) cmd_q <= IDLE_CMD;
        else     cmd_q <= cmd_d;
    end

    assign pwr_on_q = cmd_q.pwr;
    assign aux_on_q = cmd_q.aux;

    cdt_out_stage u_out (
        .cmd      (cmd_q),
        .drv_en   (drv_en),
        .aux_inv  (aux_inv),
        .pwr_gate (pwr_gate),
        .aux_gate (aux_gate),
        .aux_oe   (aux_oe)
    );
endmodule

// File: rtl/cdt_checker.sv
module cdt_checker (
    input logic clk,
    input logic rst,
    input logic drv_en,
    input logic aux_inv,
    input logic zvs_on,
    input logic zvs_off,
    input logic pwr_gate,
    input logic aux_gate,
    input logic aux_oe,
    input logic pwr_on,
    input logic aux_on,
    input logic rise_p,
    input logic fall_p,
    input logic on_run,
    input logic off_run
);
    a_r12_no_overlap: assert property (@(posedge clk) disable iff (rst)
        drv_en |-> !(pwr_gate && (aux_gate ^ aux_inv)));

    a_r9_sleep_outputs: assert property (@(posedge clk) disable iff (rst)
        !drv_en |-> (!pwr_gate && !aux_gate && !aux_oe));

    a_r10_wake_idle: assert property (@(posedge clk) disable iff (rst)
        !drv_en |=> (!pwr_on && aux_on));

    a_r3_rise_aux_off: assert property (@(posedge clk) disable iff (rst)
        (drv_en && rise_p) |=> !aux_on);

    a_r3_pwr_after_aux: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_on) |-> !aux_on);

    a_r4_fall_pwr_off: assert property (@(posedge clk) disable iff (rst)
        (drv_en && fall_p) |=> !pwr_on);

    a_r6_zvs_on_ends: assert property (@(posedge clk) disable iff (rst)
        (drv_en && on_run && zvs_on && !fall_p) |=> pwr_on);

    a_r6_zvs_off_ends: assert property (@(posedge clk) disable iff (rst)
        (drv_en && off_run && zvs_off && !rise_p) |=> aux_on);
endmodule

bind comp_deadtime_drv cdt_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .drv_en   (drv_en),
    .aux_inv  (aux_inv),
    .zvs_on   (zvs_on),
    .zvs_off  (zvs_off),
    .pwr_gate (pwr_gate),
    .aux_gate (aux_gate),
    .aux_oe   (aux_oe),
    .pwr_on   (pwr_on_q),
    .aux_on   (aux_on_q),
    .rise_p   (rise_p),
    .fall_p   (fall_p),
    .on_run   (t_run[0]),
    .off_run  (t_run[1])
);

// File: tb/comp_deadtime_drv_tb_top.sv
`timescale 1ns/1ps
module comp_deadtime_drv_tb_top;
    localparam int unsigned DW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwm_in = 1'b0, drv_en = 1'b1, aux_inv = 1'b0;
    logic [DW-1:0] dly_on_cyc = 8'd5, dly_off_cyc = 8'd6;
    logic zvs_on = 1'b0, zvs_off = 1'b0;
    logic pwr_gate, aux_gate, aux_oe;

    int n_chk = 0, n_fail = 0, overlaps = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    comp_deadtime_drv #(.DLY_W(DW)) dut_i (
        .clk(clk), .rst(rst), .pwm_in(pwm_in), .drv_en(drv_en), .aux_inv(aux_inv),
        .dly_on_cyc(dly_on_cyc), .dly_off_cyc(dly_off_cyc),
        .zvs_on(zvs_on), .zvs_off(zvs_off),
        .pwr_gate(pwr_gate), .aux_gate(aux_gate), .aux_oe(aux_oe)
    );

    always @(negedge clk)
        if (!rst && drv_en && pwr_gate && (aux_gate ^ aux_inv)) overlaps++;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic settle_low();
        pwm_in = 1'b0;
        tick(40);
    endtask

    task automatic t_reset();
        tick(2);
        rst = 1'b0;
        tick(1);
        chk("R1 pwr_gate after reset", pwr_gate, 1'b0);
        chk("R1 aux_gate after reset", aux_gate, 1'b1);
        chk("R1 aux_oe after reset", aux_oe, 1'b1);
    endtask

    task automatic t_rise_fall();
        dly_on_cyc = 8'd5; dly_off_cyc = 8'd6;
        pwm_in = 1'b1;
        tick(2);
        chk("R2 aux unchanged before sync latency", aux_gate, 1'b1);
        tick(1);
        chk("R3 aux off at rise", aux_gate, 1'b0);
        chk("R3 pwr off at rise", pwr_gate, 1'b0);
        tick(4);
        chk("R3 pwr still off at D-1", pwr_gate, 1'b0);
        tick(1);
        chk("R3 pwr on after D", pwr_gate, 1'b1);
        tick(10);
        pwm_in = 1'b0;
        tick(3);
        chk("R4 pwr off at fall", pwr_gate, 1'b0);
        chk("R4 aux still off at fall", aux_gate, 1'b0);
        tick(5);
        chk("R4 aux off at D-1", aux_gate, 1'b0);
        tick(1);
        chk("R4 aux on after D", aux_gate, 1'b1);
        settle_low();
    endtask

    task automatic t_zero();
        dly_on_cyc = 8'd0; dly_off_cyc = 8'd0;
        pwm_in = 1'b1;
        tick(3);
        chk("R5 zero T1 aux off", aux_gate, 1'b0);
        chk("R5 zero T1 pwr on same edge", pwr_gate, 1'b1);
        tick(5);
        pwm_in = 1'b0;
        tick(3);
        chk("R5 zero T2 pwr off", pwr_gate, 1'b0);
        chk("R5 zero T2 aux on same edge", aux_gate, 1'b1);
        settle_low();
    endtask

    task automatic t_zvs();
        dly_on_cyc = 8'd30; dly_off_cyc = 8'd30;
        zvs_on = 1'b1;
        tick(3);
        chk("R6 zvs_on ignored while idle", pwr_gate, 1'b0);
        zvs_on = 1'b0;
        pwm_in = 1'b1;
        tick(3);
        tick(4);
        chk("R6 pwr off before zvs_on", pwr_gate, 1'b0);
        zvs_on = 1'b1;
        tick(1);
        chk("R6 zvs_on ends T1", pwr_gate, 1'b1);
        zvs_on = 1'b0;
        zvs_off = 1'b1;
        tick(3);
        chk("R6 zvs_off ignored while idle", aux_gate, 1'b0);
        zvs_off = 1'b0;
        pwm_in = 1'b0;
        tick(3);
        tick(4);
        chk("R6 aux off before zvs_off", aux_gate, 1'b0);
        zvs_off = 1'b1;
        tick(1);
        chk("R6 zvs_off ends T2", aux_gate, 1'b1);
        zvs_off = 1'b0;
        settle_low();
    endtask

    task automatic t_cancel();
        dly_on_cyc = 8'd20; dly_off_cyc = 8'd4;
        pwm_in = 1'b1;
        tick(3);
        chk("R7 aux off at rise", aux_gate, 1'b0);
        tick(5);
        pwm_in = 1'b0;
        tick(3);
        tick(3);
        chk("R7 aux off before T2 end", aux_gate, 1'b0);
        tick(1);
        chk("R7 aux on T2 after cancelled rise", aux_gate, 1'b1);
        tick(25);
        chk("R7 cancelled power turn-on never happens", pwr_gate, 1'b0);
        dly_on_cyc = 8'd4; dly_off_cyc = 8'd30;
        pwm_in = 1'b1;
        tick(12);
        pwm_in = 1'b0;
        tick(3);
        chk("R7 pwr off at fall", pwr_gate, 1'b0);
        tick(5);
        pwm_in = 1'b1;
        tick(3);
        chk("R7 aux stays off at rise in T2", aux_gate, 1'b0);
        tick(3);
        chk("R7 pwr off before restarted T1", pwr_gate, 1'b0);
        tick(1);
        chk("R7 pwr on after restarted T1", pwr_gate, 1'b1);
        tick(30);
        chk("R7 cancelled aux turn-on never happens", aux_gate, 1'b0);
        settle_low();
    endtask

    task automatic t_dly_change();
        dly_on_cyc = 8'd10;
        pwm_in = 1'b1;
        tick(3);
        dly_on_cyc = 8'd3;
        tick(9);
        chk("R8 running T1 keeps old delay", pwr_gate, 1'b0);
        tick(1);
        chk("R8 pwr on at old delay", pwr_gate, 1'b1);
        pwm_in = 1'b0;
        tick(20);
        pwm_in = 1'b1;
        tick(3);
        tick(2);
        chk("R8 new delay not yet", pwr_gate, 1'b0);
        tick(1);
        chk("R8 new delay used from next edge", pwr_gate, 1'b1);
        settle_low();
    endtask

    task automatic t_sleep_wake();
        dly_on_cyc = 8'd5; dly_off_cyc = 8'd5;
        pwm_in = 1'b1;
        tick(12);
        chk("R9 pwr on before sleep", pwr_gate, 1'b1);
        drv_en = 1'b0;
        #1;
        chk("R9 pwr low at once in sleep", pwr_gate, 1'b0);
        chk("R9 aux_oe low in sleep", aux_oe, 1'b0);
        chk("R9 aux_gate low in sleep", aux_gate, 1'b0);
        tick(5);
        chk("R9 pwr held low in sleep", pwr_gate, 1'b0);
        drv_en = 1'b1;
        #1;
        chk("R10 pwr off at wake", pwr_gate, 1'b0);
        chk("R10 aux on at wake", aux_gate, 1'b1);
        chk("R10 aux_oe back on", aux_oe, 1'b1);
        tick(20);
        chk("R10 high level at wake starts nothing", pwr_gate, 1'b0);
        pwm_in = 1'b0;
        tick(10);
        pwm_in = 1'b1;
        tick(3);
        chk("R10 first rise aux off", aux_gate, 1'b0);
        tick(4);
        chk("R10 first rise pwr waits", pwr_gate, 1'b0);
        tick(1);
        chk("R10 first rise pwr on", pwr_gate, 1'b1);
        settle_low();
    endtask

    task automatic t_polarity();
        aux_inv = 1'b1;
        #1;
        chk("R11 inverted aux on reads 0", aux_gate, 1'b0);
        pwm_in = 1'b1;
        tick(3);
        chk("R11 inverted aux off reads 1", aux_gate, 1'b1);
        tick(10);
        chk("R11 pwr on in inverted mode", pwr_gate, 1'b1);
        settle_low();
        chk("R11 inverted aux on after fall", aux_gate, 1'b0);
        aux_inv = 1'b0;
        #1;
        chk("R11 true aux on reads 1", aux_gate, 1'b1);
    endtask

    initial begin
        t_reset();
        t_rise_fall();
        t_zero();
        t_zvs();
        t_cancel();
        t_dly_change();
        t_sleep_wake();
        t_polarity();
        n_chk++;
        if (overlaps != 0) begin
            n_fail++;
            $display("FAIL R12 overlap cycles: actual=%0d expected=0", overlaps);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=expired expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule